// File: doc/BRIEF.md
# Multiplexed Bus Cycle Demultiplexer

This block is glue logic placed beside a small processor whose single 8-bit bus is shared over time. In one state the bus carries the low byte of the address. In a later state it carries the upper address bits together with a two-bit code that names the kind of cycle. In the data state it carries the data itself. The block watches the processor's 3-bit state code and the bus on each clock. It rebuilds a stable 14-bit address and decodes the cycle code into separate memory-read, memory-write and I/O command strobes, plus a fetch indication.

The read-type strobes stay up through any wait states that a slow device requests with a low ready input, and they remain up into the data state. The write strobe fires only in the data state with ready high, and the written byte is captured from the bus on that edge. A flag records that the processor entered the interrupt-acknowledge variant of the first address state. External logic can use it to drive a vector in place of the fetched opcode.

Top module: `bus_demux`

## Requirements
- R1: After reset the address reads 0, all three strobes and the fetch indication are low, and the interrupt flag is low.
- R2: A clock edge with state code 010 (address-low state) or 110 (address-low state with interrupt recognised) loads bus bits 7..0 into address bits 7..0.
- R3: A clock edge with state code 100 (address-high state) loads bus bits 5..0 into address bits 13..8 and loads the cycle code from bus bit 7 (high bit) and bus bit 6 (low bit). Bus bits 7..6 never appear in the address.
- R4: The read strobe is high while the state code is 001 (data) or 000 (wait) in a cycle whose code is 00 (instruction fetch) or 10 (memory read).
- R5: The write strobe is high only while the state code is 001 with ready high in a cycle whose code is 11 (memory write). The same edge loads the bus byte into the write-data output.
- R6: The I/O strobe is high while the state code is 001 or 000 in a cycle whose code is 01 (I/O command).
- R7: The fetch indication is high from the edge after an address-high state with code 00 until the edge of the next address-low state.
- R8: An edge with state code 110 sets the interrupt flag. An edge with state code 010 clears it.
- R9: No strobe is raised in a wait or data state unless an address-high state came after the most recent address-low, halt (011) or internal (101, 111) state.
- R10: All strobes are low while the state code is 101, 111, 010, 110, 100 or 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| state_i | input | 3 | Processor state code |
| bus_i | input | 8 | Shared address/data bus as seen by the block |
| ready_i | input | 1 | High when the addressed device can complete the transfer |
| addr_o | output | 14 | Reassembled address |
| cycle_o | output | 2 | Latched cycle code {high bit, low bit} |
| mem_rd_o | output | 1 | Memory read strobe (fetch or read cycles) |
| mem_wr_o | output | 1 | Memory write strobe |
| io_cmd_o | output | 1 | I/O command strobe |
| fetch_o | output | 1 | Current machine cycle is an opcode fetch |
| wr_data_o | output | 8 | Byte captured during the write strobe |
| intr_o | output | 1 | Current cycle began with interrupt recognised |

## Verification
The hardest condition to reach is a wait or data state that is not preceded by an address-high state. A processor that behaves normally never produces it, so a defect in the arming logic stays hidden. The bench drives the state code directly. It ends a full cycle, then issues an address-low state or a halt and goes straight into wait and data states, and checks that every strobe stays low. Long wait stretches with ready low are inserted in both read and write cycles. These confirm that read-type strobes persist across them and that the write strobe waits for ready.

// File: rtl/bus_demux.sv
module bus_demux #(
  parameter int ADDR_W = 14,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        state_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        cycle_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              io_cmd_o,
  output logic              fetch_o,
  output logic [BUS_W-1:0]  wr_data_o,
  output logic              intr_o
);
  localparam int HI_W = ADDR_W - BUS_W;

  localparam logic [2:0] ST_WAIT = 3'b000;
  localparam logic [2:0] ST_DATA = 3'b001;
  localparam logic [2:0] ST_ALO  = 3'b010;
  localparam logic [2:0] ST_HALT = 3'b011;
  localparam logic [2:0] ST_AHI  = 3'b100;
  localparam logic [2:0] ST_INT5 = 3'b101;
  localparam logic [2:0] ST_ALOI = 3'b110;
  localparam logic [2:0] ST_INT4 = 3'b111;

  localparam logic [1:0] CY_FETCH = 2'b00;
  localparam logic [1:0] CY_IO    = 2'b01;
  localparam logic [1:0] CY_READ  = 2'b10;
  localparam logic [1:0] CY_WRITE = 2'b11;

  logic [BUS_W-1:0] lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [1:0]       cyc_q;
  logic             armed_q;
  logic             live_q;
  logic             intr_q;
  logic [BUS_W-1:0] wdat_q;

  wire addr_lo_st = (state_i == ST_ALO) || (state_i == ST_ALOI);
  wire xfer_st    = (state_i == ST_DATA) || (state_i == ST_WAIT);
  wire write_now  = armed_q && (state_i == ST_DATA) && ready_i && (cyc_q == CY_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      cyc_q   <= CY_FETCH;
      armed_q <= 1'b0;
      live_q  <= 1'b0;
      intr_q  <= 1'b0;
      wdat_q  <= '0;
    end else begin
      case (state_i)
        ST_ALO, ST_ALOI: begin
          lo_q    <= bus_i;
          armed_q <= 1'b0;
          live_q  <= 1'b0;
          intr_q  <= (state_i == ST_ALOI);
        end
        ST_AHI: begin
          hi_q    <= bus_i[HI_W-1:0];
          cyc_q   <= bus_i[BUS_W-1 -: 2];
          armed_q <= 1'b1;
          live_q  <= 1'b1;
        end
        ST_HALT: begin
          armed_q <= 1'b0;
          live_q  <= 1'b0;
        end
        ST_INT4, ST_INT5: armed_q <= 1'b0;
        default: ;
      endcase
      if (write_now) wdat_q <= bus_i;
    end
  end

  assign addr_o    = {hi_q, lo_q};
  assign cycle_o   = cyc_q;
  assign mem_rd_o  = armed_q && xfer_st && ((cyc_q == CY_FETCH) || (cyc_q == CY_READ));
  assign io_cmd_o  = armed_q && xfer_st && (cyc_q == CY_IO);
  assign mem_wr_o  = write_now;
  assign fetch_o   = live_q && (cyc_q == CY_FETCH);
  assign wr_data_o = wdat_q;
  assign intr_o    = intr_q;

  logic unused_ok;
  assign unused_ok = addr_lo_st;
endmodule

module bus_demux_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  state_i,
  input logic [7:0]  bus_i,
  input logic        ready_i,
  input logic [13:0] addr_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        io_cmd_o,
  input logic        intr_o
);
  assert_alo_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == 3'b010) |=> (addr_o[7:0] == $past(bus_i)));
  assert_ahi_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == 3'b100) |=> (addr_o[13:8] == $past(bus_i[5:0])));
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_o, mem_wr_o, io_cmd_o}));
  assert_wr_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (state_i == 3'b001 && ready_i));
  assert_intr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == 3'b110) |=> intr_o);
  assert_quiet_states_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i[2] || state_i[1]) |-> !(mem_rd_o || mem_wr_o || io_cmd_o));
endmodule

bind bus_demux bus_demux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_i(state_i), .bus_i(bus_i), .ready_i(ready_i),
  .addr_o(addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .io_cmd_o(io_cmd_o),
  .intr_o(intr_o)
);

// File: tb/bus_demux_test.sv
module bus_demux_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  state_i = 3'b011;
  logic [7:0]  bus_i = '0;
  logic        ready_i = 1'b1;
  logic [13:0] addr_o;
  logic [1:0]  cycle_o;
  logic        mem_rd_o, mem_wr_o, io_cmd_o, fetch_o, intr_o;
  logic [7:0]  wr_data_o;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bus_demux uut (
    .clk(clk), .rst_n(rst_n), .state_i(state_i), .bus_i(bus_i), .ready_i(ready_i),
    .addr_o(addr_o), .cycle_o(cycle_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .io_cmd_o(io_cmd_o), .fetch_o(fetch_o), .wr_data_o(wr_data_o), .intr_o(intr_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] s, input logic [7:0] b, input logic r);
    @(negedge clk);
    state_i = s; bus_i = b; ready_i = r;
    #5;
  endtask

  task automatic strobes(input string tag, input logic rd, input logic wr, input logic io);
    chk({tag, " rd"}, {15'd0, mem_rd_o}, {15'd0, rd});
    chk({tag, " wr"}, {15'd0, mem_wr_o}, {15'd0, wr});
    chk({tag, " io"}, {15'd0, io_cmd_o}, {15'd0, io});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) step(3'b001, 8'hFF, 1'b1);
    chk("R1 addr", {2'b0, addr_o}, 16'h0);
    chk("R1 fetch", {15'd0, fetch_o}, 16'h0);
    chk("R1 intr", {15'd0, intr_o}, 16'h0);
    rst_n = 1'b1;
    step(3'b011, 8'h00, 1'b1);
    strobes("R1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fetch;
    step(3'b010, 8'h34, 1'b1);
    step(3'b100, 8'h2A, 1'b1);
    chk("R2 lo", {8'd0, addr_o[7:0]}, 16'h34);
    strobes("R10 ahi", 1'b0, 1'b0, 1'b0);
    step(3'b001, 8'h07, 1'b1);
    chk("R3 addr", {2'b0, addr_o}, 16'h2A34);
    strobes("R4 fetch data", 1'b1, 1'b0, 1'b0);
    chk("R7 fetch", {15'd0, fetch_o}, 16'h1);
    step(3'b111, 8'h00, 1'b1);
    strobes("R10 t4", 1'b0, 1'b0, 1'b0);
    chk("R7 fetch hold", {15'd0, fetch_o}, 16'h1);
    step(3'b010, 8'h00, 1'b1);
    step(3'b101, 8'h00, 1'b1);
    chk("R7 fetch clear", {15'd0, fetch_o}, 16'h0);
  endtask

  task automatic t_read_wait;
    step(3'b010, 8'h80, 1'b1);
    step(3'b100, 8'h87, 1'b1);
    step(3'b000, 8'h00, 1'b0);
    chk("R3 read addr", {2'b0, addr_o}, 16'h0780);
    chk("R3 cycle", {14'd0, cycle_o}, 16'h2);
    strobes("R4 wait1", 1'b1, 1'b0, 1'b0);
    chk("R7 no fetch", {15'd0, fetch_o}, 16'h0);
    step(3'b000, 8'h00, 1'b0);
    strobes("R4 wait2", 1'b1, 1'b0, 1'b0);
    step(3'b001, 8'h5C, 1'b1);
    strobes("R4 data", 1'b1, 1'b0, 1'b0);
    step(3'b101, 8'h00, 1'b1);
    strobes("R10 t5", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_write;
    step(3'b010, 8'h55, 1'b1);
    step(3'b100, 8'hC1, 1'b1);
    step(3'b000, 8'h9A, 1'b0);
    chk("R3 hi masked", {2'b0, addr_o}, 16'h0155);
    strobes("R5 wait", 1'b0, 1'b0, 1'b0);
    step(3'b001, 8'h9A, 1'b0);
    strobes("R5 not ready", 1'b0, 1'b0, 1'b0);
    step(3'b001, 8'h9A, 1'b1);
    strobes("R5 data", 1'b0, 1'b1, 1'b0);
    step(3'b111, 8'h11, 1'b1);
    strobes("R5 after", 1'b0, 1'b0, 1'b0);
    chk("R5 data byte", {8'd0, wr_data_o}, 16'h9A);
  endtask

  task automatic t_io;
    step(3'b010, 8'h0B, 1'b1);
    step(3'b100, 8'h40, 1'b1);
    step(3'b000, 8'h00, 1'b0);
    strobes("R6 wait", 1'b0, 1'b0, 1'b1);
    step(3'b001, 8'h00, 1'b1);
    strobes("R6 data", 1'b0, 1'b0, 1'b1);
    chk("R6 addr", {2'b0, addr_o}, 16'h000B);
  endtask

  task automatic t_intr;
    step(3'b110, 8'h12, 1'b1);
    step(3'b100, 8'h00, 1'b1);
    chk("R8 set", {15'd0, intr_o}, 16'h1);
    chk("R2 loi", {8'd0, addr_o[7:0]}, 16'h12);
    step(3'b001, 8'hC7, 1'b1);
    strobes("R4 intr fetch", 1'b1, 1'b0, 1'b0);
    chk("R8 hold", {15'd0, intr_o}, 16'h1);
    step(3'b010, 8'h13, 1'b1);
    step(3'b100, 8'h00, 1'b1);
    chk("R8 clear", {15'd0, intr_o}, 16'h0);
  endtask

  task automatic t_unarmed;
    step(3'b010, 8'h20, 1'b1);
    step(3'b000, 8'h00, 1'b0);
    strobes("R9 after lo", 1'b0, 1'b0, 1'b0);
    step(3'b001, 8'h00, 1'b1);
    strobes("R9 data after lo", 1'b0, 1'b0, 1'b0);
    step(3'b100, 8'hC0, 1'b1);
    step(3'b011, 8'h00, 1'b1);
    strobes("R10 halt", 1'b0, 1'b0, 1'b0);
    step(3'b001, 8'h00, 1'b1);
    strobes("R9 data after halt", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_fetch;
        t_read_wait;
        t_write;
        t_io;
        t_intr;
        t_unarmed;
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule